// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block turns a 64-bit send command into a single 32-bit store into the register space of a target core. The command names the target core and a per-byte keep mask, and carries the 32-bit payload in its upper half. Masked bytes must keep whatever the target word already holds. When any keep bit is set, the block therefore reads the target word first, merges it with the payload, and then writes it back. When no keep bit is set, it writes the payload straight away.

There are two command kinds, selected by the register offset that the command was written to. The mailbox kind addresses one of eight mailbox words in the target core. The arbitrary kind addresses any 16-bit location in the target core. Commands arrive on a valid/ready port. A command is transferred on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole time an operation is in flight, so the sender must hold the command stable until it is taken.

The memory master toward the target cores is also valid/ready. A request stays asserted and unchanged until `req_ready` accepts it. Every request, read or write, is answered by exactly one `rsp_valid` pulse, one cycle or more later. Completion and decode errors are reported on a one-cycle `res_valid` pulse, with `res_err` marking the error case.

Top module: `mbx_remote_writer`

## Requirements
- R1: The target core is the 10-bit field at command bits 25:16. A valid command whose core is at or above `NUM_CORES` is answered, one cycle after acceptance, by `res_valid` and `res_err` both high, and it issues no memory request.
- R2: When keep bits 30:27 are all zero, no read is issued. A single write of command bits 63:32 goes to the target.
- R3: When any keep bit is set, a read of the target word is issued first, followed by a write. In that write, byte i (bits 8i+7:8i) keeps the old value when command bit 27+i is 1, and takes byte i of bits 63:32 otherwise.
- R4: A mailbox command (offset `MBX_OFS`) targets address `MBX_BASE + 0x20 + (cmd & 0x1C)`, so command bits 4:2 pick one of eight words.
- R5: An arbitrary command (offset `ANY_OFS`) targets address `cmd[15:0]`.
- R6: A command is acted on only when `cmd_is64` is high and `cmd_offset` equals `MBX_OFS` or `ANY_OFS`. Any other command is accepted and discarded. It causes no request, no `res_valid` pulse and no busy period.
- R7: `busy` rises on the cycle after an acting command is accepted and stays high until the final write response. While `busy` is high, `cmd_ready` is low.
- R8: A successful operation ends with a one-cycle `res_valid` pulse with `res_err` low, one cycle after the write response.
- R9: While `req_valid` is high and `req_ready` is low, the request (write flag, core, address, data) holds its value into the next cycle.
- R10: After reset, `busy`, `req_valid` and `res_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_offset | input | OFS_W | Register offset the command was written to |
| cmd_is64 | input | 1 | Command was a full 64-bit write |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | Operation in flight |
| res_valid | output | 1 | One-cycle result pulse |
| res_err | output | 1 | Result is a decode error |
| req_valid | output | 1 | Memory request offered |
| req_ready | input | 1 | Memory request taken |
| req_write | output | 1 | 1 for write, 0 for read |
| req_core | output | 10 | Target core number |
| req_addr | output | 16 | Target word address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Response to the oldest request |
| rsp_rdata | input | 32 | Read data, meaningful for read responses |

## Verification
The checker watches a fixed set of rules on every cycle:
- Request stability under back-pressure.
- `cmd_ready` staying low while busy.
- The immediate error pulse for an out-of-range core.
- Whether an accepted command starts with a read or with a write, depending on its keep bits.
- Silence after a discarded command.
- A success pulse only after a response.

The following can only be shown by the directed scenarios, which compare the target memory after each operation:
- The merged byte pattern itself.
- The decoded mailbox and arbitrary addresses.
- That ignored or erroneous commands leave memory and read counts untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CMD_W  = 64;
  localparam int WORD_W = 32;
  localparam int ID_W   = 10;
  localparam int ADDR_W = 16;
  localparam int NBYTES = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } mbx_state_e;

  typedef struct packed {
    logic              act;
    logic              bad_core;
    logic [ID_W-1:0]   core;
    logic [ADDR_W-1:0] addr;
    logic [NBYTES-1:0] keep;
    logic [WORD_W-1:0] pay;
  } mbx_op_t;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
#(
  parameter int              NUM_CORES = 4,
  parameter int              OFS_W     = 12,
  parameter logic [OFS_W-1:0] MBX_OFS  = 12'h100,
  parameter logic [OFS_W-1:0] ANY_OFS  = 12'h108,
  parameter logic [ADDR_W-1:0] MBX_BASE = 16'h0000
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic [OFS_W-1:0] offset,
  input  logic             is64,
  output mbx_op_t          op
);
  localparam int              KEEP_LSB = 27;
  localparam int              ID_LSB   = 16;
  localparam logic [ID_W:0]   CORE_LIM = (ID_W+1)'(NUM_CORES);
  localparam logic [ADDR_W-1:0] MBX_WIN = MBX_BASE + 16'h0020;

  logic              is_mbx, is_any;
  logic [ID_W-1:0]   core_id;
  logic [ADDR_W-1:0] mbx_addr;
  logic              unused_spare;

  assign is_mbx       = is64 && (offset == MBX_OFS);
  assign is_any       = is64 && (offset == ANY_OFS);
  assign core_id      = cmd[ID_LSB +: ID_W];
  assign mbx_addr     = MBX_WIN + {11'b0, cmd[4:2], 2'b00};
  assign unused_spare = cmd[31] ^ cmd[26];

  always_comb begin
    op          = '0;
    op.act      = is_mbx || is_any;
    op.core     = core_id;
    op.bad_core = ({1'b0, core_id} >= CORE_LIM);
    op.addr     = is_mbx ? mbx_addr : cmd[ADDR_W-1:0];
    op.keep     = cmd[KEEP_LSB +: NBYTES];
    op.pay      = cmd[CMD_W-1 -: WORD_W];
  end
endmodule

// File: rtl/mbx_byte_merge.sv
module mbx_byte_merge
  import mbx_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [NBYTES-1:0] keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
  end
endmodule

// File: rtl/mbx_rmw_seq.sv
module mbx_rmw_seq
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  mbx_op_t           op,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] merged,
  output logic              idle,
  output logic              req_valid,
  output logic              req_write,
  output logic [ID_W-1:0]   req_core,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] pay_q,
  output logic [NBYTES-1:0] keep_q,
  output logic              res_valid,
  output logic              res_err
);
  mbx_state_e st;

  assign idle      = (st == ST_IDLE);
  assign req_valid = (st == ST_RD_REQ) || (st == ST_WR_REQ);
  assign req_write = (st == ST_WR_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      req_core  <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      pay_q     <= '0;
      keep_q    <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take && op.act) begin
            if (op.bad_core) begin
              res_valid <= 1'b1;
              res_err   <= 1'b1;
            end else begin
              req_core  <= op.core;
              req_addr  <= op.addr;
              pay_q     <= op.pay;
              keep_q    <= op.keep;
              req_wdata <= op.pay;
              st        <= (op.keep != '0) ? ST_RD_REQ : ST_WR_REQ;
            end
          end
        end
        ST_RD_REQ:  if (req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (rsp_valid) begin
            req_wdata <= merged;
            st        <= ST_WR_REQ;
          end
        end
        ST_WR_REQ:  if (req_ready) st <= ST_WR_WAIT;
        ST_WR_WAIT: begin
          if (rsp_valid) begin
            res_valid <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_remote_writer.sv
module mbx_remote_writer
  import mbx_pkg::*;
#(
  parameter int               NUM_CORES = 4,
  parameter int               OFS_W     = 12,
  parameter logic [OFS_W-1:0] MBX_OFS   = 12'h100,
  parameter logic [OFS_W-1:0] ANY_OFS   = 12'h108,
  parameter logic [15:0]      MBX_BASE  = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [OFS_W-1:0] cmd_offset,
  input  logic             cmd_is64,
  input  logic [63:0]      cmd_data,
  output logic             busy,
  output logic             res_valid,
  output logic             res_err,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [9:0]       req_core,
  output logic [15:0]      req_addr,
  output logic [31:0]      req_wdata,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_rdata
);
  mbx_op_t           op;
  logic              idle;
  logic [WORD_W-1:0] pay_q, merged;
  logic [NBYTES-1:0] keep_q;

  assign cmd_ready = idle;
  assign busy      = !idle;

  mbx_cmd_decode #(
    .NUM_CORES(NUM_CORES), .OFS_W(OFS_W), .MBX_OFS(MBX_OFS),
    .ANY_OFS(ANY_OFS), .MBX_BASE(MBX_BASE)
  ) u_dec (
    .cmd(cmd_data), .offset(cmd_offset), .is64(cmd_is64), .op(op)
  );

  mbx_byte_merge u_merge (
    .old_word(rsp_rdata), .new_word(pay_q), .keep(keep_q), .merged(merged)
  );

  mbx_rmw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(cmd_valid && cmd_ready), .op(op),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .merged(merged),
    .idle(idle), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .pay_q(pay_q), .keep_q(keep_q), .res_valid(res_valid), .res_err(res_err)
  );
endmodule

// File: rtl/mbx_remote_writer_chk.sv
module mbx_remote_writer_chk #(
  parameter int               NUM_CORES = 4,
  parameter int               OFS_W     = 12,
  parameter logic [OFS_W-1:0] MBX_OFS   = 12'h100,
  parameter logic [OFS_W-1:0] ANY_OFS   = 12'h108
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [OFS_W-1:0] cmd_offset,
  input logic             cmd_is64,
  input logic [63:0]      cmd_data,
  input logic             busy,
  input logic             res_valid,
  input logic             res_err,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [9:0]       req_core,
  input logic [15:0]      req_addr,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid
);
  logic acc, legal, core_ok;
  assign acc     = cmd_valid && cmd_ready;
  assign legal   = cmd_is64 && (cmd_offset == MBX_OFS || cmd_offset == ANY_OFS);
  assign core_ok = {1'b0, cmd_data[25:16]} < 11'(NUM_CORES);

  p_bad_core_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && legal && !core_ok |=> res_valid && res_err && !req_valid && !busy);
  p_nokeep_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && legal && core_ok && cmd_data[30:27] == 4'b0 |=> req_valid && req_write);
  p_keep_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && legal && core_ok && cmd_data[30:27] != 4'b0 |=> req_valid && !req_write);
  p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !legal |=> !busy && !res_valid && !req_valid);
  p_no_take_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  p_done_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_err |-> $past(rsp_valid) && !busy);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_core)
      && $stable(req_addr) && $stable(req_wdata));
endmodule

bind mbx_remote_writer mbx_remote_writer_chk #(
  .NUM_CORES(NUM_CORES), .OFS_W(OFS_W), .MBX_OFS(MBX_OFS), .ANY_OFS(ANY_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_offset(cmd_offset), .cmd_is64(cmd_is64), .cmd_data(cmd_data),
  .busy(busy), .res_valid(res_valid), .res_err(res_err), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_core(req_core),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid)
);

// File: tb/tb_mbx_remote_writer.sv
module tb_mbx_remote_writer;
  localparam int NCORE = 4;
  localparam logic [11:0] OMBX = 12'h100;
  localparam logic [11:0] OANY = 12'h108;
  localparam logic [15:0] BASE = 16'h0000;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_is64 = 0;
  logic [11:0] cmd_offset = '0;
  logic [63:0] cmd_data = '0;
  logic cmd_ready, busy, res_valid, res_err;
  logic req_valid, req_write, req_ready = 1;
  logic [9:0] req_core;
  logic [15:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata = '0;
  logic rsp_valid = 0;
  logic stall_mode = 0;

  int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0;
  logic [31:0] mem [int];

  always #10 clk = ~clk;

  mbx_remote_writer #(.NUM_CORES(NCORE), .OFS_W(12), .MBX_OFS(OMBX),
    .ANY_OFS(OANY), .MBX_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_offset(cmd_offset), .cmd_is64(cmd_is64), .cmd_data(cmd_data),
    .busy(busy), .res_valid(res_valid), .res_err(res_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  function automatic int key(input logic [9:0] c, input logic [15:0] a);
    return int'(c) * 65536 + int'(a);
  endfunction

  function automatic logic [31:0] peek(input logic [9:0] c, input logic [15:0] a);
    int k = key(c, a);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  // target model: answers each accepted request one cycle later
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (stall_mode) req_ready <= ~req_ready; else req_ready <= 1'b1;
    if (rst_n && req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      if (req_write) begin
        mem[key(req_core, req_addr)] = req_wdata;
        n_wr++;
      end else begin
        rsp_rdata <= peek(req_core, req_addr);
        n_rd++;
      end
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] pay, input logic [3:0] keep,
                                     input logic [9:0] core, input logic [15:0] low);
    return {pay, 1'b0, keep, 1'b0, core, low};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // offers a command, returns whether a result pulse came and its error bit
  task automatic send(input logic [11:0] ofs, input logic full, input logic [63:0] d,
                      output logic got, output logic err, output logic saw_busy);
    @(negedge clk);
    cmd_valid = 1; cmd_offset = ofs; cmd_is64 = full; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    saw_busy = busy && !cmd_ready;
    got = 0; err = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (res_valid) begin got = 1; err = res_err; end
      else @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R10 busy", busy, 0);
    check("R10 cmd_ready", cmd_ready, 1);
    check("R10 req_valid", req_valid, 0);
    check("R10 res_valid", res_valid, 0);
  endtask

  task automatic t_mbx_plain;
    logic g, e, b; int r0 = n_rd, w0 = n_wr;
    send(OMBX, 1, mk(32'hA5A5_1234, 4'b0000, 10'd1, 16'h000C), g, e, b);
    check("R8 done", {g, e}, 2'b10);
    check("R7 busy after take", b, 1);
    check("R4 mailbox slot 3", peek(1, BASE + 16'h2C), 32'hA5A5_1234);
    check("R2 no read", n_rd - r0, 0);
    check("R2 one write", n_wr - w0, 1);
  endtask

  task automatic t_any_keep;
    logic g, e, b; int r0;
    mem[key(2, 16'h1234)] = 32'h1122_3344;
    r0 = n_rd;
    send(OANY, 1, mk(32'hAABB_CCDD, 4'b0101, 10'd2, 16'h1234), g, e, b);
    check("R8 done", {g, e}, 2'b10);
    check("R3 R5 merged word", peek(2, 16'h1234), 32'hAA22_CC44);
    check("R3 one read", n_rd - r0, 1);
  endtask

  task automatic t_keep_all;
    logic g, e, b;
    mem[key(3, 16'h0040)] = 32'hDEAD_BEEF;
    send(OANY, 1, mk(32'h0000_0000, 4'b1111, 10'd3, 16'h0040), g, e, b);
    check("R3 all kept", peek(3, 16'h0040), 32'hDEAD_BEEF);
  endtask

  task automatic t_bad_core;
    logic g, e, b; int r0 = n_rd, w0 = n_wr;
    send(OMBX, 1, mk(32'h5555_5555, 4'b0000, 10'd4, 16'h0000), g, e, b);
    check("R1 error pulse", {g, e}, 2'b11);
    check("R1 no access", (n_rd - r0) + (n_wr - w0), 0);
    send(OANY, 1, mk(32'h5555_5555, 4'b0011, 10'h3FF, 16'h0010), g, e, b);
    check("R1 high id error", {g, e}, 2'b11);
  endtask

  task automatic t_ignored;
    logic g, e, b; int w0 = n_wr, r0 = n_rd;
    send(12'h104, 1, mk(32'h7777_7777, 4'b0000, 10'd1, 16'h000C), g, e, b);
    check("R6 wrong offset no result", g, 0);
    send(OMBX, 0, mk(32'h7777_7777, 4'b0000, 10'd1, 16'h000C), g, e, b);
    check("R6 narrow write no result", g, 0);
    check("R6 no access", (n_wr - w0) + (n_rd - r0), 0);
    check("R6 memory untouched", peek(1, BASE + 16'h2C), 32'hA5A5_1234);
  endtask

  task automatic t_stall;
    logic g, e, b;
    stall_mode = 1;
    mem[key(0, BASE + 16'h3C)] = 32'h0102_0304;
    send(OMBX, 1, {32'hF0F0_F0F0, 1'b1, 4'b1000, 1'b1, 10'd0, 16'h001F}, g, e, b);
    stall_mode = 0;
    check("R7 busy under stall", b, 1);
    check("R9 R3 R4 stalled merge slot 7", peek(0, BASE + 16'h3C), 32'h01F0_F0F0);
    check("R8 done after stall", {g, e}, 2'b10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mbx_plain();
    t_any_keep();
    t_keep_all();
    t_bad_core();
    t_ignored();
    t_stall();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule